// File: doc/BRIEF.md
# Five-Channel Timer Register Interface

This block is the 32-bit memory-mapped front end for a group of five timer channels. It decodes word-aligned addresses inside a 4 KiB window. It holds each channel's control word and initial count, and drives both to the channel logic. On reads it returns those values together with the live count that each channel reports. A shared interrupt-status register collects one pending bit per channel. Channel expiry sets a bit, and software clears it by writing 1.

Each channel has a level interrupt output. The output is the AND of the channel's enable bit in its control word and its pending bit. The bus is a plain valid/write/address/data port. Writes take effect at the clock edge. Read data is combinational, so it is valid in the same cycle as the request. The timer channels themselves are not part of this block. The watchdog-control location is a read-only placeholder.

Top module: `tmr_bus_regs`

## Requirements
- R1: Control words sit at byte offsets 0x00, 0x04, 0x20, 0x24 and 0x40 for channels 0 to 4. Initial counts sit at 0x08, 0x0C, 0x28, 0x2C and 0x48. A full 32-bit write to either kind of register is read back unchanged.
- R2: Reads of the live-count offsets 0x10, 0x14, 0x30, 0x34 and 0x50 (channels 0 to 4) return that channel's 32-bit slice of `ch_live_cnt` in the same cycle.
- R3: The status register sits at offset 0x18. Bit i reads 1 from the cycle after `ch_expire[i]` is sampled high. Bits 31:5 always read 0.
- R4: Writing the status register clears every bit written as 1 and leaves every bit written as 0 unchanged. If an expiry and a clear hit the same bit in the same cycle, the bit stays set.
- R5: `irq[i]` is high exactly when bit 29 (interrupt enable) of channel i's control word and status bit i are both 1. It follows either change in the cycle after the write or expiry that causes it.
- R6: Writes to the live-count offsets change no register. Control words, initial counts and status keep their values.
- R7: The watchdog-control offset 0x1C always reads 0x00000400, and writes to it are ignored.
- R8: Two kinds of access count as unmapped: an offset not listed above, and any address whose bits 1:0 are not 00. Reads of an unmapped address return 0, and writes to one change nothing.
- R9: After reset, every control word, initial count and status bit is 0, and all `irq` outputs are low.
- R10: `bus_rdata` is 0 in every cycle that is not a read, that is, when `bus_valid` is 0 or `bus_write` is 1.
- R11: `ch_ctrl` and `ch_init` carry each channel's register contents at bit slice [32*i +: 32] from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, 0 when not reading |
| ch_expire | input | 5 | Per-channel expiry pulse from the timer channels |
| ch_live_cnt | input | 160 | Live count of each channel, 32 bits per channel |
| ch_ctrl | output | 160 | Control word of each channel, 32 bits per channel |
| ch_init | output | 160 | Initial count of each channel, 32 bits per channel |
| irq | output | 5 | Level interrupt per channel |

## Verification
A wrong decode shows up on the very next read. The read returns another channel's value, or the written data appears on the wrong slice of `ch_ctrl` or `ch_init` one cycle after the write. A corrupt status bit reaches `irq` in the cycle after the expiry or clear, as long as the enable bit is set. With the enable bit clear, the fault shows only when the status register is read. The bench therefore reads status and samples `irq` after every expiry, every clear and every change to the enable bit. It also covers the cycle in which an expiry and a clear collide.

// File: rtl/tmr_regs_pkg.sv
`timescale 1ns/1ps
package tmr_regs_pkg;
    localparam int DW       = 32;
    localparam int NCH      = 5;
    localparam int AW       = 12;
    localparam int CH_IDX_W = $clog2(NCH);
    localparam int WORD_W   = AW - 2;
    localparam int IE_BIT   = 29;
    localparam logic [DW-1:0] WDOG_RST = 32'h0000_0400;

    typedef enum logic [2:0] {
        K_NONE, K_CTRL, K_INIT, K_LIVE, K_STAT, K_WDOG
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [CH_IDX_W-1:0]   ch;
    } reg_sel_t;

    // Map a byte address to a register kind and channel number.
    // Low words 0..15: bit 3 picks channel pair (0/1 or 2/3), bit 0 the
    // channel in the pair, bits 2:1 the register kind; kind 3 holds the
    // shared status and watchdog words. Channel 4 sits at words 16/18/20.
    function automatic reg_sel_t decode_addr(input logic [AW-1:0] a);
        reg_sel_t          s;
        logic [WORD_W-1:0] w;
        s.kind = K_NONE;
        s.ch   = '0;
        w      = a[AW-1:2];
        if (a[1:0] == 2'b00) begin
            if (w < WORD_W'(16)) begin
                s.ch = {1'b0, w[3], w[0]};
                case (w[2:1])
                    2'd0: s.kind = K_CTRL;
                    2'd1: s.kind = K_INIT;
                    2'd2: s.kind = K_LIVE;
                    default: begin
                        if (w == WORD_W'(6))      s.kind = K_STAT;
                        else if (w == WORD_W'(7)) s.kind = K_WDOG;
                        else                      s.kind = K_NONE;
                        s.ch = '0;
                    end
                endcase
            end else begin
                s.ch = CH_IDX_W'(4);
                if (w == WORD_W'(16))      s.kind = K_CTRL;
                else if (w == WORD_W'(18)) s.kind = K_INIT;
                else if (w == WORD_W'(20)) s.kind = K_LIVE;
                else begin
                    s.kind = K_NONE;
                    s.ch   = '0;
                end
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/tmr_addr_dec.sv
`timescale 1ns/1ps
module tmr_addr_dec
    import tmr_regs_pkg::*;
(
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    output reg_sel_t      sel,
    output logic          wr_en,
    output logic          rd_en
);
    always_comb begin
        sel   = decode_addr(bus_addr);
        wr_en = bus_valid &  bus_write;
        rd_en = bus_valid & ~bus_write;
    end
endmodule

// File: rtl/tmr_chan_regs.sv
`timescale 1ns/1ps
module tmr_chan_regs
    import tmr_regs_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  reg_sel_t      sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] init_q
);
    logic hit;
    assign hit = wr_en && (sel.ch == CH_IDX_W'(CH_ID));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            init_q <= '0;
        end else if (hit) begin
            if (sel.kind == K_CTRL) ctrl_q <= wdata;
            if (sel.kind == K_INIT) init_q <= wdata;
        end
    end
endmodule

// File: rtl/tmr_stat_reg.sv
`timescale 1ns/1ps
module tmr_stat_reg
    import tmr_regs_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_en,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] expire,
    input  logic [NCH-1:0] ie,
    output logic [NCH-1:0] stat_q,
    output logic [NCH-1:0] irq
);
    logic [NCH-1:0] clr_mask;

    always_comb begin
        clr_mask = clr_en ? wdata[NCH-1:0] : '0;
        irq      = stat_q & ie;
    end

    // Expiry is ORed in after the clear, so a same-cycle expiry wins.
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_mask) | expire;
    end
endmodule

// File: rtl/tmr_rd_mux.sv
`timescale 1ns/1ps
module tmr_rd_mux
    import tmr_regs_pkg::*;
(
    input  logic                    rd_en,
    input  reg_sel_t                sel,
    input  logic [NCH-1:0][DW-1:0]  ctrl_a,
    input  logic [NCH-1:0][DW-1:0]  init_a,
    input  logic [NCH-1:0][DW-1:0]  live_a,
    input  logic [NCH-1:0]          stat_q,
    output logic [DW-1:0]           rdata
);
    logic ch_ok;
    assign ch_ok = sel.ch < CH_IDX_W'(NCH);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel.kind)
                K_CTRL: if (ch_ok) rdata = ctrl_a[sel.ch];
                K_INIT: if (ch_ok) rdata = init_a[sel.ch];
                K_LIVE: if (ch_ok) rdata = live_a[sel.ch];
                K_STAT: rdata = DW'(stat_q);
                K_WDOG: rdata = WDOG_RST;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_bus_regs.sv
`timescale 1ns/1ps
module tmr_bus_regs
    import tmr_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    ch_expire,
    input  logic [NCH*DW-1:0] ch_live_cnt,
    output logic [NCH*DW-1:0] ch_ctrl,
    output logic [NCH*DW-1:0] ch_init,
    output logic [NCH-1:0]    irq
);
    reg_sel_t               sel;
    logic                   wr_en;
    logic                   rd_en;
    logic [NCH-1:0][DW-1:0] ctrl_a;
    logic [NCH-1:0][DW-1:0] init_a;
    logic [NCH-1:0][DW-1:0] live_a;
    logic [NCH-1:0]         ie_v;
    logic [NCH-1:0]         stat_q;
    logic                   stat_clr;

    tmr_addr_dec u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .sel       (sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan_regs #(.CH_ID(g)) u_regs (
            .clk    (clk),
            .rst    (rst),
            .sel    (sel),
            .wr_en  (wr_en),
            .wdata  (bus_wdata),
            .ctrl_q (ctrl_a[g]),
            .init_q (init_a[g])
        );
        assign ch_ctrl[g*DW +: DW] = ctrl_a[g];
        assign ch_init[g*DW +: DW] = init_a[g];
        assign live_a[g]           = ch_live_cnt[g*DW +: DW];
        assign ie_v[g]             = ctrl_a[g][IE_BIT];
    end

    assign stat_clr = wr_en && (sel.kind == K_STAT);

    tmr_stat_reg u_stat (
        .clk    (clk),
        .rst    (rst),
        .clr_en (stat_clr),
        .wdata  (bus_wdata),
        .expire (ch_expire),
        .ie     (ie_v),
        .stat_q (stat_q),
        .irq    (irq)
    );

    tmr_rd_mux u_mux (
        .rd_en  (rd_en),
        .sel    (sel),
        .ctrl_a (ctrl_a),
        .init_a (init_a),
        .live_a (live_a),
        .stat_q (stat_q),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/tmr_bus_regs_chk.sv
`timescale 1ns/1ps
module tmr_bus_regs_chk
    import tmr_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_rdata,
    input logic [NCH-1:0]    ch_expire,
    input logic [NCH-1:0]    irq,
    input logic [NCH*DW-1:0] ch_ctrl,
    input logic [NCH*DW-1:0] ch_init,
    input logic [NCH-1:0]    stat_q,
    input reg_kind_e         sel_kind
);
    // R3 / R4: an expiry always leaves its status bit set
    assert_expire_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (ch_expire != '0) |=> ((stat_q & $past(ch_expire)) == $past(ch_expire)));

    // R5: no interrupt without a pending bit
    assert_irq_needs_pend_R5: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~stat_q) == '0));

    // R6: live-count writes leave the channel registers alone
    assert_live_ro_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && sel_kind == K_LIVE) |=> ($stable(ch_ctrl) && $stable(ch_init)));

    // R7: watchdog placeholder reads constant
    assert_wdog_const_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == 12'h01C) |-> (bus_rdata == WDOG_RST));

    // R8: unmapped reads return zero, unmapped writes change nothing
    assert_unmapped_rd_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && sel_kind == K_NONE) |-> (bus_rdata == '0));
    assert_unmapped_wr_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && sel_kind == K_NONE && ch_expire == '0)
        |=> ($stable(ch_ctrl) && $stable(ch_init) && $stable(stat_q)));

    // R9: reset clears status and interrupts
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (stat_q == '0 && irq == '0));

    // R10: no read data outside reads
    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid || bus_write) |-> (bus_rdata == '0));
endmodule

bind tmr_bus_regs tmr_bus_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ch_expire (ch_expire),
    .irq       (irq),
    .ch_ctrl   (ch_ctrl),
    .ch_init   (ch_init),
    .stat_q    (stat_q),
    .sel_kind  (sel.kind)
);

// File: tb/sim_tmr_bus_regs.sv
`timescale 1ns/1ps
module sim_tmr_bus_regs;
    logic         clk = 1'b0;
    logic         rst;
    logic         bus_valid;
    logic         bus_write;
    logic [11:0]  bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [4:0]   ch_expire;
    logic [159:0] ch_live_cnt;
    logic [159:0] ch_ctrl;
    logic [159:0] ch_init;
    logic [4:0]   irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_bus_regs u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_expire(ch_expire), .ch_live_cnt(ch_live_cnt), .ch_ctrl(ch_ctrl),
        .ch_init(ch_init), .irq(irq)
    );

    function automatic logic [11:0] off_ctrl(input int ch);
        case (ch) 0: return 12'h000; 1: return 12'h004; 2: return 12'h020;
                  3: return 12'h024; default: return 12'h040; endcase
    endfunction
    function automatic logic [11:0] off_init(input int ch);
        return off_ctrl(ch) + 12'h008;
    endfunction
    function automatic logic [11:0] off_live(input int ch);
        return off_ctrl(ch) + 12'h010;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pulse_expire(input logic [4:0] m);
        @(negedge clk);
        ch_expire = m;
        @(negedge clk);
        ch_expire = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < 5; c++) begin
            bus_rd(off_ctrl(c), v); chk("R9 ctrl after reset", v, 32'h0);
            bus_rd(off_init(c), v); chk("R9 init after reset", v, 32'h0);
        end
        bus_rd(12'h018, v); chk("R9 status after reset", v, 32'h0);
        chk("R9 irq after reset", {27'b0, irq}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        for (int c = 0; c < 5; c++) begin
            bus_wr(off_ctrl(c), 32'h0100_0000 + 32'h111 * c);
            bus_wr(off_init(c), 32'hC0DE_0000 + c);
        end
        for (int c = 0; c < 5; c++) begin
            bus_rd(off_ctrl(c), v); chk("R1 ctrl readback", v, 32'h0100_0000 + 32'h111 * c);
            bus_rd(off_init(c), v); chk("R1 init readback", v, 32'hC0DE_0000 + c);
            chk("R11 ch_ctrl slice", ch_ctrl[c*32 +: 32], 32'h0100_0000 + 32'h111 * c);
            chk("R11 ch_init slice", ch_init[c*32 +: 32], 32'hC0DE_0000 + c);
        end
    endtask

    task automatic t_live();
        logic [31:0] v;
        for (int c = 0; c < 5; c++) ch_live_cnt[c*32 +: 32] = 32'h7700_0000 + 32'h10 * c + 3;
        for (int c = 0; c < 5; c++) begin
            bus_rd(off_live(c), v); chk("R2 live read", v, 32'h7700_0000 + 32'h10 * c + 3);
        end
        for (int c = 0; c < 5; c++) bus_wr(off_live(c), 32'hFFFF_FFFF);
        for (int c = 0; c < 5; c++) begin
            bus_rd(off_ctrl(c), v); chk("R6 ctrl after live write", v, 32'h0100_0000 + 32'h111 * c);
            bus_rd(off_init(c), v); chk("R6 init after live write", v, 32'hC0DE_0000 + c);
        end
        bus_rd(12'h018, v); chk("R6 status after live write", v, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        bus_wr(off_ctrl(2), 32'h2000_0000);
        chk("R5 irq idle with enable", {27'b0, irq}, 32'h0);
        pulse_expire(5'b00100);
        bus_rd(12'h018, v); chk("R3 status after expire 2", v, 32'h4);
        chk("R5 irq after expire 2", {27'b0, irq}, 32'h4);
        pulse_expire(5'b00001);
        bus_rd(12'h018, v); chk("R3 status after expire 0", v, 32'h5);
        chk("R5 irq gated by enable", {27'b0, irq}, 32'h4);
        bus_wr(12'h018, 32'h0000_0001);
        bus_rd(12'h018, v); chk("R4 clear bit 0 only", v, 32'h4);
        @(negedge clk);
        ch_expire = 5'b00100; bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = 12'h018; bus_wdata = 32'h4;
        @(negedge clk);
        ch_expire = '0; bus_valid = 1'b0; bus_write = 1'b0;
        bus_rd(12'h018, v); chk("R4 expiry beats clear", v, 32'h4);
        bus_wr(off_ctrl(2), 32'h0);
        chk("R5 irq drops with enable", {27'b0, irq}, 32'h0);
        bus_wr(off_ctrl(2), 32'h2000_0000);
        chk("R5 irq returns with enable", {27'b0, irq}, 32'h4);
        pulse_expire(5'b11011);
        bus_rd(12'h018, v); chk("R3 all five set", v, 32'h1F);
        bus_wr(12'h018, 32'hFFFF_FFFF);
        bus_rd(12'h018, v); chk("R3 upper bits zero after full clear", v, 32'h0);
        chk("R5 irq low after clear", {27'b0, irq}, 32'h0);
    endtask

    task automatic t_wdog();
        logic [31:0] v;
        bus_rd(12'h01C, v); chk("R7 wdog reset value", v, 32'h400);
        bus_wr(12'h01C, 32'h0);
        bus_rd(12'h01C, v); chk("R7 wdog after write", v, 32'h400);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        logic [159:0] c0, i0;
        c0 = ch_ctrl; i0 = ch_init;
        bus_wr(12'h044, 32'hDEAD_BEEF);
        bus_wr(12'h03C, 32'hDEAD_BEEF);
        bus_wr(12'hFFC, 32'hDEAD_BEEF);
        bus_wr(12'h001, 32'hDEAD_BEEF);
        bus_wr(12'h01A, 32'hFFFF_FFFF);
        chk("R8 ctrl unchanged lo", c0[31:0], ch_ctrl[31:0]);
        chk("R8 ctrl unchanged ch4", c0[159:128], ch_ctrl[159:128]);
        chk("R8 init unchanged ch4", i0[159:128], ch_init[159:128]);
        bus_rd(12'h044, v); chk("R8 read 0x044", v, 32'h0);
        bus_rd(12'h002, v); chk("R8 misaligned read", v, 32'h0);
        bus_rd(12'h800, v); chk("R8 read 0x800", v, 32'h0);
        pulse_expire(5'b00010);
        bus_wr(12'h01A, 32'hFFFF_FFFF);
        bus_rd(12'h018, v); chk("R8 misaligned status write ignored", v, 32'h2);
        bus_wr(12'h018, 32'h2);
    endtask

    task automatic t_idle_rdata();
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = off_ctrl(1);
        #1 chk("R10 rdata with valid low", bus_rdata, 32'h0);
        bus_valid = 1'b1; bus_write = 1'b1; bus_wdata = 32'h0100_0111;
        #1 chk("R10 rdata during write", bus_rdata, 32'h0);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
        bus_wdata = '0; ch_expire = '0; ch_live_cnt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_live();
        t_status();
        t_wdog();
        t_unmapped();
        t_idle_rdata();
        finish_run();
    end
endmodule